// File: doc/BRIEF.md
# Strobed Control Register Bank

The block holds three 8-bit control registers: a system register, a monitor-routing register and a clock register. A host loads them over one shared parallel data bus. For a write, the host places a byte on the bus, pulls the common active-low output enable low, and then pulses the select line of the target register low and back high. The register takes the bus value on the rising edge of its select, but only if the enable is still low at that point. The clock register also needs its read/write line at 0 (write).

The three select lines arrive asynchronously to the block clock. Each one passes through a two-flop synchroniser. A rising edge is then detected in the clock domain, and the bus is sampled one cycle after the detected edge. The registers drive their contents straight out as control levels.

The clock register is also decoded into four outputs:
- a sample-rate index;
- an internal/external sync flag;
- an external clock type;
- a flag for code combinations that have no defined meaning.

Top module: `strobe_reg_bank`

## Requirements
- R1: After reset the system register holds 0x08 (phantom off set, codec held powered down with bit 7 = 0), the monitor register holds 0x00 and the clock register holds 0x00 (internal sync, rate index 0).
- R2: A rising edge on `sysSelN` while `outEnN` is low loads `busData` into the system register. Take the select rising between clock edges. The new value is not yet visible after the third rising clock edge that follows, and it is visible after the fourth.
- R3: A rising edge on `monSelN` while `outEnN` is low loads `busData` into the monitor register, with all eight bits stored as written.
- R4: A rising edge on `clkSelN` while `outEnN` is low and `rwSel` is 0 loads `busData` into the clock register.
- R5: A select rising edge while `outEnN` is high leaves every register unchanged.
- R6: A rising edge on `clkSelN` while `rwSel` is 1 leaves the clock register unchanged.
- R7: A write to one register leaves the other two registers unchanged.
- R8: `rateIdx` equals clock register bits [2:0], and `extSync` equals clock register bit 3 (1 = external).
- R9: With bit 3 = 0 (internal), `extType` is 3 (none), and `modeInvalid` is 1 exactly when bits [2:0] are 110 or 111. Bit 4 has no effect on validity in this mode.
- R10: With bit 3 = 1, the pair {bit 4, bits [2:0]} decodes as follows, each with `modeInvalid` = 0: 0/000 gives `extType` 0 (S/PDIF), 0/010 gives `extType` 1 (word clock 1×FS), and 1/010 gives `extType` 2 (word clock 256×FS).
- R11: With bit 3 = 1, any other combination of bit 4 and bits [2:0] gives `modeInvalid` = 1 and `extType` = 3.
- R12: A select that stays high causes no further load. Bus changes with `outEnN` low and no new select edge leave the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busData | input | 8 | Shared write data bus |
| outEnN | input | 1 | Active-low enable gating all writes |
| rwSel | input | 1 | Clock register direction, 0 = write |
| sysSelN | input | 1 | System register select, loads on rising edge |
| monSelN | input | 1 | Monitor register select, loads on rising edge |
| clkSelN | input | 1 | Clock register select, loads on rising edge |
| sysCtrl | output | 8 | System register contents |
| monCtrl | output | 8 | Monitor register contents |
| clkCtrl | output | 8 | Clock register contents |
| rateIdx | output | 3 | Sample-rate index from clock register |
| extSync | output | 1 | 1 = external sync selected |
| extType | output | 2 | 0 S/PDIF, 1 word clock 1×FS, 2 word clock 256×FS, 3 none |
| modeInvalid | output | 1 | Undefined clock register combination |

## Verification
The hold and capture checks assume that the bus, the enable and the read/write line stay constant from before a select falls until several clock cycles after it rises. Only then is the value sampled one cycle after the synchronised edge the one the host meant. The stimulus sets these inputs first and keeps them fixed for six cycles after each select rises, and it moves no more than one select at a time. The selects idle high from reset, so the synchronisers, which reset high, see no false edge.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int NUM_SEL  = 3;
  localparam int SEL_SYS  = 0;
  localparam int SEL_MON  = 1;
  localparam int SEL_CLK  = 2;

  // clock register field positions (decoded below)
  localparam int RATE_LSB = 0;
  localparam int RATE_W   = 3;
  localparam int SYNC_BIT = 3;
  localparam int WSEL_BIT = 4;

  localparam logic [1:0] EXT_SPDIF = 2'd0;
  localparam logic [1:0] EXT_WC1   = 2'd1;
  localparam logic [1:0] EXT_WC256 = 2'd2;
  localparam logic [1:0] EXT_NONE  = 2'd3;

  typedef struct packed {
    logic wrSys;
    logic wrMon;
    logic wrClk;
  } wrStrobe_t;
endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEL-1:0] selN,
  output wrStrobe_t          wrStb
);
  logic [NUM_SEL-1:0] riseDet;
  logic [NUM_SEL-1:0] stbQ;

  genvar g;
  generate
    for (g = 0; g < NUM_SEL; g++) begin : gSel
      // SYNC_STAGES synchroniser flops plus one history flop for edge detect
      logic [SYNC_STAGES:0] shiftQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shiftQ <= '1;
        else       shiftQ <= {shiftQ[SYNC_STAGES-1:0], selN[g]};
      end
      assign riseDet[g] = shiftQ[SYNC_STAGES-1] & ~shiftQ[SYNC_STAGES];

      AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
        stbQ[g] |=> !stbQ[g]); // R12
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbQ <= '0;
    else       stbQ <= riseDet;
  end

  assign wrStb.wrSys = stbQ[SEL_SYS];
  assign wrStb.wrMon = stbQ[SEL_MON];
  assign wrStb.wrClk = stbQ[SEL_CLK];
endmodule

// File: rtl/srb_datapath.sv
module srb_datapath
  import srb_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] SYS_RST = 8'h08,
  parameter logic [DATA_W-1:0] MON_RST = 8'h00,
  parameter logic [DATA_W-1:0] CLK_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         wrStb,
  input  logic [DATA_W-1:0] busData,
  input  logic              outEnN,
  input  logic              rwSel,
  output logic [DATA_W-1:0] sysQ,
  output logic [DATA_W-1:0] monQ,
  output logic [DATA_W-1:0] clkQ
);
  logic takeSys, takeMon, takeClk;

  assign takeSys = wrStb.wrSys & ~outEnN;
  assign takeMon = wrStb.wrMon & ~outEnN;
  assign takeClk = wrStb.wrClk & ~outEnN & ~rwSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysQ <= SYS_RST;
      monQ <= MON_RST;
      clkQ <= CLK_RST;
    end else begin
      if (takeSys) sysQ <= busData;
      if (takeMon) monQ <= busData;
      if (takeClk) clkQ <= busData;
    end
  end

  AST_SYS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStb.wrSys || outEnN) |=> $stable(sysQ)); // R5
  AST_MON_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStb.wrMon || outEnN) |=> $stable(monQ)); // R5
  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStb.wrClk || outEnN || rwSel) |=> $stable(clkQ)); // R6
  AST_SYS_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.wrSys && !outEnN) |=> sysQ == $past(busData)); // R2
  AST_CLK_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.wrClk && !outEnN && !rwSel) |=> clkQ == $past(busData)); // R4
endmodule

// File: rtl/srb_clk_decode.sv
module srb_clk_decode
  import srb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] clkQ,
  output logic [RATE_W-1:0] rateIdx,
  output logic              extSync,
  output logic [1:0]        extType,
  output logic              modeInvalid
);
  localparam logic [RATE_W-1:0] RATE_MAX = RATE_W'(5);

  always_comb begin
    rateIdx     = clkQ[RATE_LSB +: RATE_W];
    extSync     = clkQ[SYNC_BIT];
    extType     = EXT_NONE;
    modeInvalid = 1'b0;
    if (!extSync) begin
      modeInvalid = (rateIdx > RATE_MAX);
    end else begin
      case ({clkQ[WSEL_BIT], rateIdx})
        4'b0_000: extType = EXT_SPDIF;
        4'b0_010: extType = EXT_WC1;
        4'b1_010: extType = EXT_WC256;
        default:  modeInvalid = 1'b1;
      endcase
    end
  end

  AST_INT_NO_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    !extSync |-> extType == EXT_NONE); // R9
  AST_INT_RATE_OK: assert property (@(posedge clk) disable iff (!rstN)
    (!extSync && !modeInvalid) |-> rateIdx <= RATE_MAX); // R9
  AST_EXT_TYPE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (extSync && !modeInvalid) |-> extType != EXT_NONE); // R10
  AST_EXT_BAD_NONE: assert property (@(posedge clk) disable iff (!rstN)
    (extSync && modeInvalid) |-> extType == EXT_NONE); // R11
endmodule

// File: rtl/strobe_reg_bank.sv
module strobe_reg_bank
  import srb_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] SYS_RST     = 8'h08,
  parameter logic [DATA_W-1:0] MON_RST     = 8'h00,
  parameter logic [DATA_W-1:0] CLK_RST     = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busData,
  input  logic              outEnN,
  input  logic              rwSel,
  input  logic              sysSelN,
  input  logic              monSelN,
  input  logic              clkSelN,
  output logic [DATA_W-1:0] sysCtrl,
  output logic [DATA_W-1:0] monCtrl,
  output logic [DATA_W-1:0] clkCtrl,
  output logic [2:0]        rateIdx,
  output logic              extSync,
  output logic [1:0]        extType,
  output logic              modeInvalid
);
  logic [NUM_SEL-1:0] selN;
  wrStrobe_t          wrStb;

  assign selN[SEL_SYS] = sysSelN;
  assign selN[SEL_MON] = monSelN;
  assign selN[SEL_CLK] = clkSelN;

  srb_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .selN  (selN),
    .wrStb (wrStb)
  );

  srb_datapath #(
    .DATA_W  (DATA_W),
    .SYS_RST (SYS_RST),
    .MON_RST (MON_RST),
    .CLK_RST (CLK_RST)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .wrStb   (wrStb),
    .busData (busData),
    .outEnN  (outEnN),
    .rwSel   (rwSel),
    .sysQ    (sysCtrl),
    .monQ    (monCtrl),
    .clkQ    (clkCtrl)
  );

  srb_clk_decode #(.DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rstN        (rstN),
    .clkQ        (clkCtrl),
    .rateIdx     (rateIdx),
    .extSync     (extSync),
    .extType     (extType),
    .modeInvalid (modeInvalid)
  );
endmodule

// File: tb/strobe_reg_bank_tb.sv
module strobe_reg_bank_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] busData;
  logic       outEnN, rwSel, sysSelN, monSelN, clkSelN;
  logic [7:0] sysCtrl, monCtrl, clkCtrl;
  logic [2:0] rateIdx;
  logic       extSync, modeInvalid;
  logic [1:0] extType;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  logic [7:0] mSys, mMon, mClk;
  logic [23:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  strobe_reg_bank u_dut (
    .clk(clk), .rstN(rstN), .busData(busData), .outEnN(outEnN), .rwSel(rwSel),
    .sysSelN(sysSelN), .monSelN(monSelN), .clkSelN(clkSelN),
    .sysCtrl(sysCtrl), .monCtrl(monCtrl), .clkCtrl(clkCtrl),
    .rateIdx(rateIdx), .extSync(extSync), .extType(extType),
    .modeInvalid(modeInvalid)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // expected decode, straight from the requirements
  function automatic logic [5:0] expDecode(input logic [7:0] c);
    logic [1:0] t;
    logic       bad;
    t = 2'd3; bad = 1'b0;
    if (!c[3]) bad = (c[2:0] >= 3'd6);
    else if (c[4] == 1'b0 && c[2:0] == 3'b000) t = 2'd0;
    else if (c[4] == 1'b0 && c[2:0] == 3'b010) t = 2'd1;
    else if (c[4] == 1'b1 && c[2:0] == 3'b010) t = 2'd2;
    else bad = 1'b1;
    return {c[2:0], t, bad};
  endfunction

  task automatic pushExp(input string tag);
    expQ.push_back({mSys, mMon, mClk});
    tagQ.push_back(tag);
  endtask

  // monitor: compares queued expectations against the outputs
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        logic [23:0] e;
        logic [5:0]  d;
        string       tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        d  = expDecode(e[7:0]);
        check(tg, "sysCtrl", sysCtrl, e[23:16]);
        check(tg, "monCtrl", monCtrl, e[15:8]);
        check(tg, "clkCtrl", clkCtrl, e[7:0]);
        check({tg, "/R8"}, "rateIdx", rateIdx, d[5:3]);
        check({tg, "/R8"}, "extSync", extSync, e[3]);
        check(tg, "extType", extType, d[2:1]);
        check(tg, "modeInvalid", modeInvalid, d[0]);
      end
    end
  end

  task automatic setSel(input int idx, input logic v);
    case (idx)
      0: sysSelN = v;
      1: monSelN = v;
      default: clkSelN = v;
    endcase
  endtask

  task automatic writeReg(input int idx, input logic [7:0] data, input logic oen,
                          input logic rw, input string tag);
    @(negedge clk);
    busData = data; outEnN = oen; rwSel = rw;
    repeat (2) @(negedge clk);
    setSel(idx, 1'b0);
    repeat (3) @(negedge clk);
    setSel(idx, 1'b1);
    repeat (6) @(negedge clk);
    outEnN = 1'b1; rwSel = 1'b0;
    if (!oen && (idx != 2 || !rw)) begin
      case (idx)
        0: mSys = data;
        1: mMon = data;
        default: mClk = data;
      endcase
    end
    pushExp(tag);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busData = 8'h00; outEnN = 1'b1; rwSel = 1'b0;
    sysSelN = 1'b1; monSelN = 1'b1; clkSelN = 1'b1;
    mSys = 8'h08; mMon = 8'h00; mClk = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    pushExp("R1");
    repeat (2) @(negedge clk);

    // R2 latency: select rises between edges, sample after edges 3 and 4
    busData = 8'h85; outEnN = 1'b0;
    repeat (2) @(negedge clk);
    sysSelN = 1'b0;
    repeat (3) @(negedge clk);
    sysSelN = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", "sysCtrl after 3 edges", sysCtrl, 8'h08);
    @(negedge clk);
    check("R2", "sysCtrl after 4 edges", sysCtrl, 8'h85);
    repeat (3) @(negedge clk);
    outEnN = 1'b1;
    mSys = 8'h85;
    pushExp("R2");
    repeat (2) @(negedge clk);

    writeReg(0, 8'h4A, 1'b0, 1'b0, "R2");
    writeReg(1, 8'h3F, 1'b0, 1'b0, "R3");
    writeReg(1, 8'hC5, 1'b0, 1'b0, "R3/R7");
    writeReg(2, 8'h01, 1'b0, 1'b0, "R4");
    writeReg(2, 8'h05, 1'b0, 1'b0, "R8");
    writeReg(2, 8'h06, 1'b0, 1'b0, "R9");
    writeReg(2, 8'h07, 1'b0, 1'b0, "R9");
    writeReg(2, 8'h12, 1'b0, 1'b0, "R9");
    writeReg(2, 8'h08, 1'b0, 1'b0, "R10");
    writeReg(2, 8'h0A, 1'b0, 1'b0, "R10");
    writeReg(2, 8'h1A, 1'b0, 1'b0, "R10");
    writeReg(2, 8'h09, 1'b0, 1'b0, "R11");
    writeReg(2, 8'h18, 1'b0, 1'b0, "R11");
    writeReg(2, 8'h0E, 1'b0, 1'b0, "R11");
    writeReg(2, 8'h03, 1'b0, 1'b0, "R4/R7");
    writeReg(0, 8'hFF, 1'b1, 1'b0, "R5");
    writeReg(1, 8'h00, 1'b1, 1'b0, "R5");
    writeReg(2, 8'h1A, 1'b1, 1'b0, "R5");
    writeReg(2, 8'h0A, 1'b0, 1'b1, "R6");

    // R12: bus moves with enable low but no new select edge
    @(negedge clk);
    busData = 8'hE7; outEnN = 1'b0;
    repeat (10) @(negedge clk);
    busData = 8'h18;
    repeat (10) @(negedge clk);
    outEnN = 1'b1;
    pushExp("R12");
    repeat (4) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule